// File: doc/BRIEF.md
# Byte-Fetch Interpreter Sequencer

This block is the control core of a small 8-bit interpreter-style processor. It fetches each 16-bit opcode as two bytes, most significant byte first, over a byte-wide synchronous memory read port. It reads its operand registers one at a time from an external single-port register file of sixteen 8-bit entries, executes, and then writes results back in dedicated store cycles. It owns the 12-bit program counter and the 12-bit index register.

The memory and the register file both return read data one clock after the address is presented. The register read for X is issued in the cycle that requests the low opcode byte, because X is already known from the high byte. The Y read follows one cycle later. These overlaps fix a cycle cost for each instruction: 5 clocks without a register write, 6 clocks for a single write or for an offset jump, and 7 clocks for an add that also writes a carry. A one-cycle retire pulse marks the last cycle of every instruction, so an integrator can count retired instructions or step through them.

Top module: `bf_seq_core`

## Requirements
- R1: While reset is held and in the first cycle after it is released, PC is 0x200, the index register is 0, a memory read of address 0x200 is requested, no register write is issued and the retire pulse is low.
- R2: In the first cycle of an instruction a memory read of PC is requested, and in the second a read of PC+1 (modulo 4096). The first byte returned is opcode bits 15:8. PC advances by 2 before the execute step applies any jump or skip.
- R3: The register read address is X (opcode bits 11:8) in the second cycle of an instruction and Y (opcode bits 7:4) in the third cycle.
- R4: ANNN (top nibble 0xA) loads the index register with NNN (bits 11:0). ANNN, 1NNN, 3XNN and 5XY0 each take 5 clocks, issue no register write, and their effect on PC or the index is visible in the first cycle of the next instruction.
- R5: 6XNN writes NN (bits 7:0) into register X in cycle 6 and takes 6 clocks.
- R6: 7XNN writes (VX + NN) modulo 256 into register X in cycle 6, issues no other write (register 15 is untouched unless X is 15) and takes 6 clocks.
- R7: 8XY4 (low nibble 4) writes the low byte of VX + VY into register X in cycle 6, then writes the carry (0x01 or 0x00) into register 15 in cycle 7, and takes 7 clocks.
- R8: 1NNN sets PC to NNN.
- R9: 3XNN leaves PC at the instruction address + 4 when VX equals NN, otherwise at the instruction address + 2.
- R10: 5XY0 (low nibble 0) leaves PC at the instruction address + 4 when VX equals VY, otherwise at the instruction address + 2.
- R11: BNNN reads register 0 in cycle 4, sets PC to (V0 + NNN) modulo 4096 and takes 6 clocks.
- R12: Every other opcode, including 5XY and 8XY with any other low nibble, takes 5 clocks, writes no register, leaves the index unchanged and leaves PC at the instruction address + 2.
- R13: The retire output is high for exactly one cycle, the last one of each instruction. Register writes occur only in the writeback cycles and never while a memory read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| mem_rd_o | output | 1 | Memory read request |
| mem_addr_o | output | 12 | Memory byte address |
| mem_rdata_i | input | 8 | Memory read data, one cycle after the request |
| rf_raddr_o | output | 4 | Register file read index |
| rf_rdata_i | input | 8 | Register file read data, one cycle after the index |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 4 | Register file write index |
| rf_wdata_o | output | 8 | Register file write data |
| pc_o | output | 12 | Current program counter |
| idx_o | output | 12 | Current index register |
| retire_o | output | 1 | One-cycle pulse in the last cycle of an instruction |

## Verification
Opcodes are drawn at random from the eight implemented forms and from unimplemented ones, over random register contents. The skip forms are biased so that the equal and unequal outcomes occur about equally often. This separates a working compare from one that always or never skips, and a true no-op from an instruction decoded by its top nibble alone. Directed cases cover the corners: additions that overflow or not, a carry written to register 15 after register 15 was itself the destination, an offset jump that wraps past 0xFFF, and an opcode fetched across the wrap from 0xFFF to 0x000. Every instruction is checked for its exact clock count and write cycles, its fetch and read addresses, PC, the index register and all sixteen registers.

// File: rtl/bf_seq_pkg.sv
`timescale 1ns/1ps
package bf_seq_pkg;
    localparam int BYTE_W   = 8;
    localparam int INSTR_W  = 2 * BYTE_W;
    localparam int NIB_W    = 4;
    localparam int ADDR_W   = 12;
    localparam int REG_CNT  = 16;
    localparam int RIDX_W   = $clog2(REG_CNT);
    localparam logic [RIDX_W-1:0] FLAG_REG = RIDX_W'(REG_CNT - 1);

    typedef enum logic [2:0] {
        ST_FETCH_HI = 3'd0,
        ST_FETCH_LO = 3'd1,
        ST_LATCH_LO = 3'd2,
        ST_LATCH_VY = 3'd3,
        ST_LOAD_V0  = 3'd4,
        ST_EXEC     = 3'd5,
        ST_WR_VX    = 3'd6,
        ST_WR_VF    = 3'd7
    } seq_state_e;

    typedef enum logic [3:0] {
        OP_NOP, OP_JMP, OP_SKEQ_IMM, OP_SKEQ_REG, OP_LDI,
        OP_ADDI, OP_ADDC, OP_SETIDX, OP_JMPOFF
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [RIDX_W-1:0] x;
        logic [BYTE_W-1:0] nn;
        logic [ADDR_W-1:0] nnn;
        logic              wb_vx;
        logic              wb_vf;
        logic              need_v0;
    } dec_t;
endpackage

// File: rtl/bf_seq_decode.sv
`timescale 1ns/1ps
module bf_seq_decode
    import bf_seq_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output dec_t               dec_o
);
    logic [NIB_W-1:0] top_nib;
    logic [NIB_W-1:0] low_nib;

    assign top_nib = instr_i[INSTR_W-1 -: NIB_W];
    assign low_nib = instr_i[NIB_W-1:0];

    always_comb begin
        dec_o         = '0;
        dec_o.x       = instr_i[ADDR_W-1 -: RIDX_W];
        dec_o.nn      = instr_i[BYTE_W-1:0];
        dec_o.nnn     = instr_i[ADDR_W-1:0];
        dec_o.op      = OP_NOP;
        unique case (top_nib)
            4'h1: dec_o.op = OP_JMP;
            4'h3: dec_o.op = OP_SKEQ_IMM;
            4'h5: if (low_nib == 4'h0) dec_o.op = OP_SKEQ_REG;
            4'h6: dec_o.op = OP_LDI;
            4'h7: dec_o.op = OP_ADDI;
            4'h8: if (low_nib == 4'h4) dec_o.op = OP_ADDC;
            4'hA: dec_o.op = OP_SETIDX;
            4'hB: dec_o.op = OP_JMPOFF;
            default: dec_o.op = OP_NOP;
        endcase
        dec_o.wb_vx   = (dec_o.op == OP_LDI) || (dec_o.op == OP_ADDI) ||
                        (dec_o.op == OP_ADDC);
        dec_o.wb_vf   = (dec_o.op == OP_ADDC);
        dec_o.need_v0 = (dec_o.op == OP_JMPOFF);
    end
endmodule

// File: rtl/bf_seq_exec.sv
`timescale 1ns/1ps
module bf_seq_exec
    import bf_seq_pkg::*;
(
    input  op_e               op_i,
    input  logic [BYTE_W-1:0] nn_i,
    input  logic [ADDR_W-1:0] nnn_i,
    input  logic [BYTE_W-1:0] vx_i,
    input  logic [BYTE_W-1:0] vy_i,
    input  logic [BYTE_W-1:0] v0_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] idx_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] idx_o,
    output logic [BYTE_W-1:0] res_o,
    output logic              carry_o
);
    localparam logic [ADDR_W-1:0] SKIP_STEP = ADDR_W'(2);

    logic [BYTE_W:0]   sum_wide;
    logic [ADDR_W-1:0] pc_skip;

    assign sum_wide = {1'b0, vx_i} + {1'b0, vy_i};
    assign pc_skip  = pc_i + SKIP_STEP;

    always_comb begin
        pc_o    = pc_i;
        idx_o   = idx_i;
        res_o   = vx_i;
        carry_o = 1'b0;
        unique case (op_i)
            OP_JMP:      pc_o  = nnn_i;
            OP_SKEQ_IMM: if (vx_i == nn_i) pc_o = pc_skip;
            OP_SKEQ_REG: if (vx_i == vy_i) pc_o = pc_skip;
            OP_LDI:      res_o = nn_i;
            OP_ADDI:     res_o = vx_i + nn_i;
            OP_ADDC: begin
                res_o   = sum_wide[BYTE_W-1:0];
                carry_o = sum_wide[BYTE_W];
            end
            OP_SETIDX:   idx_o = nnn_i;
            OP_JMPOFF:   pc_o  = nnn_i + {{(ADDR_W-BYTE_W){1'b0}}, v0_i};
            default: ;
        endcase
    end
endmodule

// File: rtl/bf_seq_core.sv
`timescale 1ns/1ps
module bf_seq_core
    import bf_seq_pkg::*;
#(
    parameter logic [11:0] RESET_PC = 12'h200
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    output logic              mem_rd_o,
    output logic [11:0]       mem_addr_o,
    input  logic [7:0]        mem_rdata_i,
    output logic [3:0]        rf_raddr_o,
    input  logic [7:0]        rf_rdata_i,
    output logic              rf_we_o,
    output logic [3:0]        rf_waddr_o,
    output logic [7:0]        rf_wdata_o,
    output logic [11:0]       pc_o,
    output logic [11:0]       idx_o,
    output logic              retire_o
);
    localparam logic [ADDR_W-1:0] ADDR_ONE  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] FETCH_LEN = ADDR_W'(2);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] idx;
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
        logic [BYTE_W-1:0] vx;
        logic [BYTE_W-1:0] vy;
        logic [BYTE_W-1:0] v0;
        logic              carry;
    } core_t;

    core_t core_d, core_q;
    dec_t  dec;

    logic [ADDR_W-1:0] ex_pc, ex_idx;
    logic [BYTE_W-1:0] ex_res;
    logic              ex_carry;

    bf_seq_decode u_decode (
        .instr_i (INSTR_W'({core_q.hi, core_q.lo})),
        .dec_o   (dec)
    );

    bf_seq_exec u_exec (
        .op_i    (dec.op),
        .nn_i    (dec.nn),
        .nnn_i   (dec.nnn),
        .vx_i    (core_q.vx),
        .vy_i    (core_q.vy),
        .v0_i    (core_q.v0),
        .pc_i    (core_q.pc),
        .idx_i   (core_q.idx),
        .pc_o    (ex_pc),
        .idx_o   (ex_idx),
        .res_o   (ex_res),
        .carry_o (ex_carry)
    );

    always_comb begin
        core_d     = core_q;
        mem_rd_o   = 1'b0;
        mem_addr_o = core_q.pc;
        rf_raddr_o = dec.x;
        rf_we_o    = 1'b0;
        rf_waddr_o = dec.x;
        rf_wdata_o = core_q.vx;
        retire_o   = 1'b0;
        unique case (core_q.st)
            ST_FETCH_HI: begin
                mem_rd_o  = 1'b1;
                core_d.st = ST_FETCH_LO;
            end
            ST_FETCH_LO: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = core_q.pc + ADDR_ONE;
                core_d.hi  = mem_rdata_i;
                rf_raddr_o = mem_rdata_i[RIDX_W-1:0];
                core_d.st  = ST_LATCH_LO;
            end
            ST_LATCH_LO: begin
                core_d.lo  = mem_rdata_i;
                core_d.vx  = rf_rdata_i;
                rf_raddr_o = mem_rdata_i[BYTE_W-1 -: RIDX_W];
                core_d.pc  = core_q.pc + FETCH_LEN;
                core_d.st  = ST_LATCH_VY;
            end
            ST_LATCH_VY: begin
                core_d.vy = rf_rdata_i;
                if (dec.need_v0) begin
                    rf_raddr_o = '0;
                    core_d.st  = ST_LOAD_V0;
                end else begin
                    core_d.st  = ST_EXEC;
                end
            end
            ST_LOAD_V0: begin
                core_d.v0 = rf_rdata_i;
                core_d.st = ST_EXEC;
            end
            ST_EXEC: begin
                core_d.pc    = ex_pc;
                core_d.idx   = ex_idx;
                core_d.vx    = ex_res;
                core_d.carry = ex_carry;
                if (dec.wb_vx) begin
                    core_d.st = ST_WR_VX;
                end else begin
                    retire_o  = 1'b1;
                    core_d.st = ST_FETCH_HI;
                end
            end
            ST_WR_VX: begin
                rf_we_o = 1'b1;
                if (dec.wb_vf) begin
                    core_d.st = ST_WR_VF;
                end else begin
                    retire_o  = 1'b1;
                    core_d.st = ST_FETCH_HI;
                end
            end
            ST_WR_VF: begin
                rf_we_o    = 1'b1;
                rf_waddr_o = FLAG_REG;
                rf_wdata_o = {{(BYTE_W-1){1'b0}}, core_q.carry};
                retire_o   = 1'b1;
                core_d.st  = ST_FETCH_HI;
            end
            default: core_d.st = ST_FETCH_HI;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            core_q    <= '0;
            core_q.pc <= RESET_PC;
        end else begin
            core_q    <= core_d;
        end
    end

    assign pc_o  = core_q.pc;
    assign idx_o = core_q.idx;

    // The low byte is always requested at the address after the high byte.
    assert_fetch_pair_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (core_q.st == ST_FETCH_HI) |=> (mem_rd_o && mem_addr_o == $past(mem_addr_o) + ADDR_ONE));

    // A retire pulse lasts one cycle and is followed by a new fetch.
    assert_retire_single_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        retire_o |=> (!retire_o && mem_rd_o));

    // Register writes never overlap a memory read request.
    assert_no_write_in_fetch_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rf_we_o |-> !mem_rd_o);

    // Back-to-back writes only occur for the carry add, the second one to the flag register.
    assert_carry_second_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rf_we_o && $past(rf_we_o)) |-> (rf_waddr_o == FLAG_REG && rf_wdata_o[BYTE_W-1:1] == '0));

    // The index register only changes after executing the set-index opcode.
    assert_idx_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(idx_o) |-> $past(core_q.st == ST_EXEC && dec.op == OP_SETIDX));

    // The operand register for an offset jump is register 0, read the cycle after Y.
    assert_v0_read_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (core_q.st == ST_LOAD_V0) |-> ($past(rf_raddr_o) == '0 && !mem_rd_o));
endmodule

// File: tb/bf_seq_core_tb_top.sv
`timescale 1ns/1ps
module bf_seq_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        mem_rd;
    logic [11:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [3:0]  rf_raddr;
    logic [7:0]  rf_rdata;
    logic        rf_we;
    logic [3:0]  rf_waddr;
    logic [7:0]  rf_wdata;
    logic [11:0] pc;
    logic [11:0] idx;
    logic        retire;

    logic [7:0]  mem  [4096];
    logic [7:0]  regs [16];
    logic [7:0]  ex_regs [16];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bf_seq_core dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .mem_rd_o    (mem_rd),
        .mem_addr_o  (mem_addr),
        .mem_rdata_i (mem_rdata),
        .rf_raddr_o  (rf_raddr),
        .rf_rdata_i  (rf_rdata),
        .rf_we_o     (rf_we),
        .rf_waddr_o  (rf_waddr),
        .rf_wdata_o  (rf_wdata),
        .pc_o        (pc),
        .idx_o       (idx),
        .retire_o    (retire)
    );

    always @(posedge clk) begin
        mem_rdata <= mem[mem_addr];
        rf_rdata  <= regs[rf_raddr];
        if (rf_we) regs[rf_waddr] <= rf_wdata;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Expected cycles, PC, index and register file for one opcode.
    task automatic model(input logic [15:0] ins, input logic [11:0] pc0, input logic [11:0] idx0,
                         output logic [11:0] epc, output logic [11:0] eidx,
                         output int ecyc, output int ewr, output string tag);
        logic [3:0]  top, x, y, lo4;
        logic [7:0]  nn;
        logic [11:0] nnn;
        logic [8:0]  s;
        top = ins[15:12]; x = ins[11:8]; y = ins[7:4]; lo4 = ins[3:0];
        nn = ins[7:0]; nnn = ins[11:0];
        for (int i = 0; i < 16; i++) ex_regs[i] = regs[i];
        epc = pc0 + 12'd2; eidx = idx0; ecyc = 5; ewr = 0; tag = "R12";
        case (top)
            4'h1: begin epc = nnn; tag = "R8"; end
            4'h3: begin if (regs[x] == nn) epc = pc0 + 12'd4; tag = "R9"; end
            4'h5: if (lo4 == 4'h0) begin
                      if (regs[x] == regs[y]) epc = pc0 + 12'd4;
                      tag = "R10";
                  end
            4'h6: begin ex_regs[x] = nn; ecyc = 6; ewr = 1; tag = "R5"; end
            4'h7: begin ex_regs[x] = regs[x] + nn; ecyc = 6; ewr = 1; tag = "R6"; end
            4'h8: if (lo4 == 4'h4) begin
                      s = {1'b0, regs[x]} + {1'b0, regs[y]};
                      ex_regs[x] = s[7:0];
                      ex_regs[15] = {7'd0, s[8]};
                      ecyc = 7; ewr = 2; tag = "R7";
                  end
            4'hA: begin eidx = nnn; tag = "R4"; end
            4'hB: begin epc = nnn + {4'd0, regs[0]}; ecyc = 6; tag = "R11"; end
            default: ;
        endcase
    endtask

    // Called in cycle 1 of an instruction (after a falling edge); returns in cycle 1 of the next.
    task automatic run_instr(input logic [15:0] ins);
        logic [11:0] pc0, idx0, epc, eidx, a1, a2;
        logic        rd1, rd2;
        logic [3:0]  ra2, ra3, ra4;
        int          ecyc, ewr, cyc, nw;
        int          wc [2];
        string       tag, ctag;
        bit          rok;
        int          bad;
        pc0 = pc; idx0 = idx;
        mem[pc0] = ins[15:8];
        mem[pc0 + 12'd1] = ins[7:0];
        model(ins, pc0, idx0, epc, eidx, ecyc, ewr, tag);
        ctag = (tag == "R8" || tag == "R9" || tag == "R10") ? "R4" : tag;
        cyc = 1; nw = 0; wc[0] = 0; wc[1] = 0;
        a1 = mem_addr; rd1 = mem_rd; a2 = '0; rd2 = 1'b0;
        ra2 = '0; ra3 = '0; ra4 = '0;
        forever begin
            if (cyc == 2) begin a2 = mem_addr; rd2 = mem_rd; ra2 = rf_raddr; end
            if (cyc == 3) ra3 = rf_raddr;
            if (cyc == 4) ra4 = rf_raddr;
            if (rf_we) begin
                if (nw < 2) wc[nw] = cyc;
                nw++;
            end
            if (retire || cyc > 40) break;
            @(negedge clk);
            cyc++;
        end
        @(negedge clk);
        chk(rd1 && a1 == pc0 && rd2 && a2 == pc0 + 12'd1, "R2", "fetch addresses",
            {a1, a2}, {pc0, pc0 + 12'd1});
        chk(ra2 == ins[11:8] && ra3 == ins[7:4], "R3", "operand read index",
            {ra2, ra3}, {ins[11:8], ins[7:4]});
        if (ins[15:12] == 4'hB)
            chk(ra4 == 4'd0, "R11", "V0 read index", ra4, 0);
        chk(cyc == ecyc, ctag, "clock count", cyc, ecyc);
        chk(pc == epc, tag, "program counter", pc, epc);
        chk(idx == eidx, "R4", "index register", idx, eidx);
        chk(nw == ewr, (ewr == 0) ? "R13" : tag, "write count", nw, ewr);
        if (ewr >= 1) chk(wc[0] == 6, tag, "first write cycle", wc[0], 6);
        if (ewr == 2) chk(wc[1] == 7, "R7", "carry write cycle", wc[1], 7);
        rok = 1'b1; bad = 0;
        for (int i = 0; i < 16; i++)
            if (rok && regs[i] !== ex_regs[i]) begin rok = 1'b0; bad = i; end
        chk(rok, (ewr == 0) ? "R12" : tag, $sformatf("register %0d", bad), regs[bad], ex_regs[bad]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R13 watchdog expired: actual hung expected retire");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] ins;
        logic [3:0]  x, y;
        int          sel;
        void'($urandom(32'd20417));
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        for (int i = 0; i < 16; i++) regs[i] = 8'($urandom);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pc == 12'h200 && idx == 12'h000, "R1", "reset PC/index", {pc, idx}, {12'h200, 12'h000});
        rst_n = 1'b1;
        #1;
        chk(mem_rd && mem_addr == 12'h200, "R1", "first read", {mem_rd, mem_addr}, {1'b1, 12'h200});
        chk(!rf_we && !retire, "R1", "no write or retire", {rf_we, retire}, 0);

        // Directed corners
        run_instr(16'hA239);
        regs[1] = 8'hFF; regs[15] = 8'h5A; run_instr(16'h7101);
        run_instr(16'h6A5C);
        regs[2] = 8'hFF; regs[3] = 8'h01; run_instr(16'h8234);
        regs[4] = 8'h10; regs[5] = 8'h20; run_instr(16'h8454);
        regs[15] = 8'h80; regs[6] = 8'h90; run_instr(16'h8F64);
        regs[7] = 8'h42; run_instr(16'h3742);
        run_instr(16'h3743);
        regs[8] = 8'h42; run_instr(16'h5780);
        run_instr(16'h5781);
        run_instr(16'h8121);
        run_instr(16'h00E0);
        run_instr(16'hF033);
        regs[0] = 8'hFF; run_instr(16'hBFFF);
        run_instr(16'h1FFF);
        run_instr(16'hA123);
        run_instr(16'h1200);

        // Constrained random
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 3) == 0)
                for (int i = 0; i < 16; i++) regs[i] = 8'($urandom);
            x = 4'($urandom); y = 4'($urandom);
            ins = 16'($urandom);
            sel = $urandom_range(0, 9);
            case (sel)
                0: ins[15:12] = 4'h1;
                1: begin
                       ins[15:8] = {4'h3, x};
                       if ($urandom_range(0, 1) == 1) ins[7:0] = regs[x];
                   end
                2: begin
                       ins = {4'h5, x, y, 4'h0};
                       if ($urandom_range(0, 1) == 1) regs[y] = regs[x];
                   end
                3: ins[15:12] = 4'h6;
                4: ins[15:12] = 4'h7;
                5: ins = {4'h8, x, y, 4'h4};
                6: ins[15:12] = 4'hA;
                7: ins[15:12] = 4'hB;
                8: ins = {($urandom_range(0, 1) == 1) ? 4'h5 : 4'h8, x, y,
                          4'($urandom_range(5, 14))};
                default: ;
            endcase
            run_instr(ins);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule